// File: doc/BRIEF.md
# Serial Codec Port, Frame-Sync Slave

This block is the data path of a serial audio codec port that follows timing from an external codec. The codec supplies the serial bit clock (the block's `clk`) and a frame-sync line. The block watches the sync line on the bit clock, decides when a frame or word begins, and then moves parallel words to and from the two serial data lines, most significant bit first. Words leave on `sdo` and arrive on `sdi` in the same bit slots.

Three framing schemes share one sync detector. In time-division mode a high level on the sync line starts a frame of several equal slots. In I2S mode every change of the word-select line, rising or falling, starts one word. In AC-link mode a high level starts a frame that opens with a fixed 16-bit tag slot and continues with data slots. Once a frame has begun, it always runs to its end. Transmit words are taken through a valid/ready pair, and received words are handed out with a one-cycle strobe.

Top module: `codec_slave_port`

## Requirements
- R1: With `mode_sel`=0 (time-division), a `fsync_in` high level captured at a rising edge of `clk` puts the MSb of the first slot on `sdo` from the next rising edge. The frame has `frame_words_m1`+1 slots, each of `word_bits_m1`+1 bits.
- R2: With `mode_sel`=1 (I2S), either a rising or a falling change of `fsync_in`, seen between two successive captures, starts exactly one word of `word_bits_m1`+1 bits one clock later. `frame_words_m1` has no effect in this mode.
- R3: With `mode_sel`=2 (AC-link), a captured high level starts a frame one clock later. The frame is a 16-bit tag slot followed by `frame_words_m1` data slots of `word_bits_m1`+1 bits.
- R4: Data moves MSb first. `sdo` changes on the rising edge of `clk`, and `sdi` is sampled on the falling edge within the same bit slot.
- R5: Sync events that arrive while a frame is in progress, before its last bit, are ignored. The frame completes unchanged, and no new frame follows unless another sync event comes.
- R6: A sync event captured during the last bit of a frame starts the next frame at once, with no idle bit in between.
- R7: `tx_ready` is high in the cycle just before each word load. A word is taken when `tx_valid` is high at that load. If `tx_valid` is low at the load, the slot is sent as zeros.
- R8: After the LSb of each slot has been sampled, `rx_valid` is high for exactly one cycle. During that cycle `rx_data` holds the slot's bits, right-justified, with the upper bits zero.
- R9: A `word_bits_m1` value below 3 gives 4-bit slots. Slot sizes span 4 to 16 bits and frames span 1 to 16 slots.
- R10: A high `rst` at a rising edge returns the block to idle. In idle `sdo` is low, `rx_valid` and `tx_ready` are low, and the block waits for a sync event.
- R11: `mode_sel`=3 behaves exactly as time-division mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock from the codec |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | 0 time-division, 1 I2S, 2 AC-link, 3 as 0 |
| word_bits_m1 | input | 4 | Slot size minus one |
| frame_words_m1 | input | 4 | Slots per frame minus one |
| fsync_in | input | 1 | Frame-sync / word-select from the codec |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data |
| tx_data | input | 16 | Transmit word, right-justified |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Word is loaded at the next rising edge |
| rx_data | output | 16 | Received word, right-justified |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |

## Verification
The bench works through several corner cases:
- A second sync arrives partway through a frame. A detector that re-arms too early would restart the slot counters and cut the frame short.
- In I2S mode, a word-select change lands exactly on the final bit. A late detector would insert an idle bit or drop the second word.
- A falling word-select edge is used. A level-only detector would never start on it.
- The AC-link tag slot is sent at 16 bits while the data slots are shorter. A design that sizes every slot alike would shift the whole stream.
- A word-size field below the minimum is applied and checked for clamping.
- A frame runs with `tx_valid` low, which must send zeros.
- Reset is applied in mid-frame, which must silence `sdo` and leave no stray receive strobe.

// File: rtl/csp_pkg.sv
package csp_pkg;

  typedef enum logic [1:0] {
    MODE_TDM = 2'd0,
    MODE_I2S = 2'd1,
    MODE_ACL = 2'd2,
    MODE_ALT = 2'd3
  } csp_mode_e;

  // Bits in a given slot: the AC-link tag slot has a fixed size, and other
  // slots use the programmed size, clamped to a minimum of four bits.
  function automatic int unsigned slot_bits(csp_mode_e mode, int unsigned slot,
                                            int unsigned size_m1, int unsigned tag_bits);
    int unsigned w;
    w = (size_m1 < 3) ? 4 : size_m1 + 1;
    if (mode == MODE_ACL && slot == 0) return tag_bits;
    return w;
  endfunction

  // Slots in one frame: one word per word-select phase in I2S mode.
  function automatic int unsigned frame_slots(csp_mode_e mode, int unsigned cnt_m1);
    if (mode == MODE_I2S) return 1;
    return cnt_m1 + 1;
  endfunction

  // Level trigger or edge trigger, depending on mode.
  function automatic logic sync_event(csp_mode_e mode, logic cur, logic prev);
    if (mode == MODE_I2S) return cur ^ prev;
    return cur;
  endfunction

endpackage

// File: rtl/csp_sync_detect.sv
module csp_sync_detect
  import csp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  csp_mode_e mode,
  input  logic      fsync_in,
  output logic      trig
);
  logic fs_q;
  logic fs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q    <= 1'b0;
      fs_prev <= 1'b0;
    end else begin
      fs_q    <= fsync_in;
      fs_prev <= fs_q;
    end
  end

  assign trig = sync_event(mode, fs_q, fs_prev);

  // R2: in I2S mode an event only ever follows a change of the captured line
  p_edge_only_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_I2S && trig) |-> (fs_q != $past(fs_q)));

  // R1: in level modes an event needs the captured line high
  p_level_only_r1: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_I2S && trig) |-> fs_q);
endmodule

// File: rtl/csp_frame_ctrl.sv
module csp_frame_ctrl
  import csp_pkg::*;
#(
  parameter int W_MAX = 16,
  parameter int N_MAX = 16,
  parameter int TAG_W = 16,
  localparam int BW = $clog2(W_MAX),
  localparam int SW = $clog2(N_MAX),
  localparam int LW = BW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  csp_mode_e     mode,
  input  logic [BW-1:0] size_m1,
  input  logic [SW-1:0] count_m1,
  input  logic          trig,
  output logic          active,
  output logic          last_bit,
  output logic          frame_end,
  output logic          word_load,
  output logic [LW-1:0] cur_len,
  output logic [LW-1:0] load_len
);
  logic [BW-1:0] bit_cnt;
  logic [SW-1:0] slot_cnt;
  logic [SW:0]   n_slots;
  logic          last_slot;
  logic          start_frame;

  assign cur_len  = LW'(slot_bits(mode, 32'(slot_cnt), 32'(size_m1), TAG_W));
  assign n_slots  = (SW+1)'(frame_slots(mode, 32'(count_m1)));

  assign last_bit    = active && ({1'b0, bit_cnt} == cur_len - 1'b1);
  assign last_slot   = ({1'b0, slot_cnt} == n_slots - 1'b1);
  assign frame_end   = last_bit && last_slot;
  assign start_frame = trig && (!active || frame_end);
  assign word_load   = start_frame || (last_bit && !last_slot);

  always_comb begin
    if (start_frame)
      load_len = LW'(slot_bits(mode, 0, 32'(size_m1), TAG_W));
    else
      load_len = LW'(slot_bits(mode, 32'(slot_cnt) + 1, 32'(size_m1), TAG_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      bit_cnt  <= '0;
      slot_cnt <= '0;
    end else if (start_frame) begin
      active   <= 1'b1;
      bit_cnt  <= '0;
      slot_cnt <= '0;
    end else if (last_bit) begin
      bit_cnt <= '0;
      if (last_slot) begin
        active   <= 1'b0;
        slot_cnt <= '0;
      end else begin
        slot_cnt <= slot_cnt + 1'b1;
      end
    end else if (active) begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // R1: an accepted sync resets the generator to slot 0, bit 0
  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    start_frame |=> (active && bit_cnt == '0 && slot_cnt == '0));

  // R5: mid-frame the transfer keeps running
  p_no_abort_r5: assert property (@(posedge clk) disable iff (rst)
    (active && !last_bit) |=> active);

  // R5: mid-frame, the bit counter only advances by one
  p_no_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (active && !last_bit) |=> (bit_cnt == $past(bit_cnt) + 1'b1));

  // R4: bit position stays inside the slot
  p_bit_bound_r4: assert property (@(posedge clk) disable iff (rst)
    active |-> ({1'b0, bit_cnt} < cur_len));

  // R10: reset leaves the block idle
  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> !active);
endmodule

// File: rtl/csp_tx_shift.sv
module csp_tx_shift #(
  parameter int W_MAX = 16,
  localparam int LW = $clog2(W_MAX) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             frame_end,
  input  logic             word_load,
  input  logic [LW-1:0]    load_len,
  input  logic [W_MAX-1:0] tx_data,
  input  logic             tx_valid,
  output logic             sdo
);
  logic [W_MAX-1:0] sh;
  logic [LW-1:0]    pad;
  logic [W_MAX-1:0] aligned;

  // left-justify the word so its MSb sits at the shifter's top bit
  assign pad     = LW'(W_MAX) - load_len;
  assign aligned = tx_data << pad;

  always_ff @(posedge clk) begin
    if (rst)
      sh <= '0;
    else if (word_load)
      sh <= tx_valid ? aligned : '0;
    else if (active && !frame_end)
      sh <= sh << 1;
    else
      sh <= '0;
  end

  assign sdo = sh[W_MAX-1];

  // R7: an empty load sends a zero MSb
  p_zero_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (word_load && !tx_valid) |=> !sdo);

  // R10: idle with no load keeps the line low
  p_idle_low_r10: assert property (@(posedge clk) disable iff (rst)
    (!active && !word_load) |=> !sdo);
endmodule

// File: rtl/csp_rx_shift.sv
module csp_rx_shift #(
  parameter int W_MAX = 16,
  localparam int LW = $clog2(W_MAX) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             last_bit,
  input  logic [LW-1:0]    cur_len,
  input  logic             sdi,
  output logic [W_MAX-1:0] rx_data,
  output logic             rx_valid
);
  logic             sdi_q;
  logic [W_MAX-1:0] sh;
  logic [W_MAX-1:0] mask;
  logic [W_MAX-1:0] word;

  // receive bit captured mid-slot, on the falling edge
  always_ff @(negedge clk) begin
    if (rst) sdi_q <= 1'b0;
    else     sdi_q <= sdi;
  end

  assign mask = {W_MAX{1'b1}} >> (LW'(W_MAX) - cur_len);
  assign word = {sh[W_MAX-2:0], sdi_q} & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (active) begin
        sh <= {sh[W_MAX-2:0], sdi_q};
        if (last_bit) begin
          rx_data  <= word;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  // R8: slots are at least four bits, so strobes never touch
  p_rx_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R10: no strobe straight out of reset
  p_rx_quiet_r10: assert property (@(posedge clk)
    rst |=> !rx_valid);
endmodule

// File: rtl/codec_slave_port.sv
module codec_slave_port
  import csp_pkg::*;
#(
  parameter int W_MAX = 16,
  parameter int N_MAX = 16,
  parameter int TAG_W = 16,
  localparam int BW = $clog2(W_MAX),
  localparam int SW = $clog2(N_MAX),
  localparam int LW = BW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_sel,
  input  logic [BW-1:0]    word_bits_m1,
  input  logic [SW-1:0]    frame_words_m1,
  input  logic             fsync_in,
  input  logic             sdi,
  output logic             sdo,
  input  logic [W_MAX-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [W_MAX-1:0] rx_data,
  output logic             rx_valid
);
  csp_mode_e     mode;
  logic          trig;
  logic          active;
  logic          last_bit;
  logic          frame_end;
  logic          word_load;
  logic [LW-1:0] cur_len;
  logic [LW-1:0] load_len;

  assign mode     = csp_mode_e'(mode_sel);
  assign tx_ready = word_load;

  csp_sync_detect u_sync (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .fsync_in (fsync_in),
    .trig     (trig)
  );

  csp_frame_ctrl #(.W_MAX(W_MAX), .N_MAX(N_MAX), .TAG_W(TAG_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .size_m1   (word_bits_m1),
    .count_m1  (frame_words_m1),
    .trig      (trig),
    .active    (active),
    .last_bit  (last_bit),
    .frame_end (frame_end),
    .word_load (word_load),
    .cur_len   (cur_len),
    .load_len  (load_len)
  );

  csp_tx_shift #(.W_MAX(W_MAX)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .frame_end (frame_end),
    .word_load (word_load),
    .load_len  (load_len),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .sdo       (sdo)
  );

  csp_rx_shift #(.W_MAX(W_MAX)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .last_bit (last_bit),
    .cur_len  (cur_len),
    .sdi      (sdi),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

  // R6: a sync on the final bit reloads the next word without a gap
  p_back_to_back_r6: assert property (@(posedge clk) disable iff (rst)
    (frame_end && trig) |-> tx_ready);

  // R7: a load never happens twice in a row
  p_ready_single_r7: assert property (@(posedge clk) disable iff (rst)
    tx_ready |=> !tx_ready);
endmodule

// File: tb/sim_codec_slave_port.sv
module sim_codec_slave_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_sel = 2'd0;
  logic [3:0]  word_bits_m1 = 4'd7;
  logic [3:0]  frame_words_m1 = 4'd0;
  logic        fsync_in = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo;
  logic [15:0] tx_data = 16'h0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] rx_data;
  logic        rx_valid;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;  // 50 MHz

  codec_slave_port u0 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .word_bits_m1(word_bits_m1),
    .frame_words_m1(frame_words_m1), .fsync_in(fsync_in), .sdi(sdi), .sdo(sdo),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  // mode, size_m1, count_m1, tx word, rx word
  localparam logic [41:0] VECS [7] = '{
    {2'd0, 4'd7,  4'd1,  16'hA5C3, 16'h3C96},
    {2'd0, 4'd15, 4'd0,  16'h8001, 16'h7FFE},
    {2'd1, 4'd11, 4'd5,  16'h0ABC, 16'h0F0F},
    {2'd1, 4'd11, 4'd5,  16'h0123, 16'h0ACE},
    {2'd2, 4'd9,  4'd2,  16'h9F35, 16'h6A17},
    {2'd3, 4'd1,  4'd2,  16'h000D, 16'h0006},
    {2'd0, 4'd3,  4'd15, 16'h0009, 16'h0005}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int m, input int slot, input int wb);
    if (m == 2 && slot == 0) return 16;
    if (wb < 3) return 4;
    return wb + 1;
  endfunction

  function automatic string mode_req(input int m);
    if (m == 1) return "R2";
    if (m == 2) return "R3";
    if (m == 3) return "R11";
    return "R1";
  endfunction

  // One frame (or two, back to back). extra_t: cycle offset of an extra sync.
  task automatic run_frame(input int m, input int wb, input int nw,
                           input logic [15:0] txw, input logic [15:0] rxw,
                           input bit txv, input int extra_t, input int reps,
                           input string req);
    int lens[16];
    int nsl, total, s, p, prevslot, err_tx, err_rx, n_rdy, idx;
    bit prevlast, inr, exp_b;
    logic [15:0] ew;
    nsl = (m == 1) ? 1 : nw + 1;
    total = 0;
    for (int k = 0; k < nsl; k++) begin
      lens[k] = exp_len(m, k, wb);
      total += lens[k];
    end
    s = 0; p = 0; prevslot = 0; prevlast = 0;
    err_tx = 0; err_rx = 0; n_rdy = 0;
    @(posedge clk); #2;
    mode_sel = 2'(m); word_bits_m1 = 4'(wb); frame_words_m1 = 4'(nw);
    tx_data = txw; tx_valid = txv;
    if (m == 1) fsync_in = ~fsync_in; else fsync_in = 1'b1;
    @(negedge clk);
    for (int t = 1; t <= total * reps + 3; t++) begin
      @(posedge clk); #2;
      if (t == extra_t) begin
        if (m == 1) fsync_in = ~fsync_in; else fsync_in = 1'b1;
      end else if (m != 1) begin
        fsync_in = 1'b0;
      end
      idx = t - 2;
      inr = (idx >= 0) && (idx < total * reps);
      sdi = inr ? rxw[lens[s] - 1 - p] : 1'b0;
      @(negedge clk);
      exp_b = inr && txv ? txw[lens[s] - 1 - p] : 1'b0;
      if (sdo !== exp_b) err_tx++;
      if (tx_ready === 1'b1) n_rdy++;
      if (rx_valid !== prevlast) err_rx++;
      else if (prevlast) begin
        ew = rxw & 16'((32'h1 << lens[prevslot]) - 1);
        if (rx_data !== ew) err_rx++;
      end
      prevlast = inr && (p == lens[s] - 1);
      prevslot = s;
      if (inr) begin
        p++;
        if (p == lens[s]) begin
          p = 0;
          s = (s + 1) % nsl;
        end
      end
    end
    chk(err_tx == 0, {req, " R4 sdo stream"}, err_tx, 0);
    chk(err_rx == 0, {req, " R8 rx words"}, err_rx, 0);
    chk(n_rdy == nsl * reps, {req, " R7 tx_ready count"}, n_rdy, nsl * reps);
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int quiet;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(sdo === 1'b0, "R10 sdo idle", int'(sdo), 0);
    chk(rx_valid === 1'b0, "R10 rx_valid idle", int'(rx_valid), 0);
    chk(tx_ready === 1'b0, "R10 tx_ready idle", int'(tx_ready), 0);

    // table walk: R1, R2 (rising then falling), R3, R9/R11 clamp
    foreach (VECS[i]) begin
      run_frame(int'(VECS[i][41:40]), int'(VECS[i][39:36]), int'(VECS[i][35:32]),
                VECS[i][31:16], VECS[i][15:0], 1'b1, -1, 1,
                (i == 5) ? "R9" : mode_req(int'(VECS[i][41:40])));
    end

    // R5: extra sync mid-frame ignored, level and edge modes
    run_frame(0, 7, 1, 16'h00B4, 16'h00E1, 1'b1, 6, 1, "R5");
    run_frame(1, 9, 0, 16'h0311, 16'h02A2, 1'b1, 4, 1, "R5");
    run_frame(2, 5, 1, 16'hC00F, 16'h1234, 1'b1, 9, 1, "R5");

    // R6: sync on final bit starts next frame with no gap
    run_frame(1, 7, 0, 16'h00C5, 16'h0093, 1'b1, 8, 2, "R6");
    run_frame(0, 4, 1, 16'h0015, 16'h000A, 1'b1, 10, 2, "R6");

    // R7: no valid word -> zeros on the line
    run_frame(0, 7, 2, 16'h00FF, 16'h0055, 1'b0, -1, 1, "R7");

    // R10: reset mid-frame
    @(posedge clk); #2;
    mode_sel = 2'd0; word_bits_m1 = 4'd15; frame_words_m1 = 4'd1;
    tx_data = 16'hFFFF; tx_valid = 1'b1; fsync_in = 1'b1;
    @(posedge clk); #2 fsync_in = 1'b0;
    repeat (4) @(posedge clk);
    #2 rst = 1'b1;
    @(posedge clk); #2 rst = 1'b0;
    quiet = 0;
    for (int t = 0; t < 24; t++) begin
      @(negedge clk);
      if (sdo !== 1'b0 || rx_valid !== 1'b0 || tx_ready !== 1'b0) quiet++;
      @(posedge clk); #2;
    end
    chk(quiet == 0, "R10 idle after mid-frame reset", quiet, 0);
    run_frame(0, 7, 0, 16'h005A, 16'h00A5, 1'b1, -1, 1, "R10 recovery R1");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule